// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block is a small bank of 8-bit clock-synthesizer control registers that the host reaches indirectly. It has one address port and one data port. The host first writes an address byte. That byte holds a 6-bit register index and a write-enable flag. The host then reads the selected register on the data port, or writes the data port to update it. A write is complete only after a three-step sequence: address with the flag set, then the data byte, then the address again with the flag clear. A read needs only the address write with the flag clear.

The bank holds the following registers:
- a reference divider,
- a memory feedback divider,
- a packed post-divider register with one 2-bit code for each of four pixel clocks,
- four pixel-clock feedback dividers at consecutive indices,
- an extended control register.

A separate clock control byte selects which of the four pixel clocks is active. Writing it with the strobe bit set produces a one-cycle strobe pulse. The block decodes the fields that belong to the active clock and drives them out continuously, so the synthesizer next to it can use them without touching the host path.

Top module: `clkgen_regport`

## Requirements
- R1: A synchronous active-high reset clears every register, the latched address byte and the clock control byte to zero, and holds the strobe low.
- R2: A write of the address byte latches the register index from bits [7:2] and the write-enable flag from bit 1. The address byte reads back as {index, flag, 0}, with bit 0 always reading zero.
- R3: A data-port write updates the addressed register only while the latched write-enable flag is 1. When the flag is 0, the write leaves every register unchanged.
- R4: The data port returns the register at the latched index. Indices 2, 4, 5 and 7 to 11 are implemented. Every other index reads 0x00 and ignores writes.
- R5: When the address byte and the data port are written in the same cycle, the data write uses the index and flag that were latched before that cycle.
- R6: The pixel-clock feedback dividers sit at index 7 + s for clock s = 0..3. The active feedback divider output equals the register for the active select.
- R7: The post-divider register (index 5) holds the 2-bit code for clock s in bits [2s+1:2s]. The active post code output is the field for the active select.
- R8: In the extended control register (index 11), bits [2:0] are the memory post-divider code. The divide-by-3 flag is high only for code 4, and the unsupported flag is high only for codes 5 to 7. Bit 4 + s is the extended post-divider bit for clock s, and it is driven out for the active select.
- R9: The clock control byte holds the active select in bits [1:0], and bit 6 is the strobe. A control write with bit 6 set raises the strobe output for exactly the next cycle. The byte reads back as written, except that bit 6 reads zero.
- R10: The reference divider output reflects index 2, and the memory feedback divider output reflects index 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Address byte write strobe |
| addr_wdata | input | 8 | Address byte: index [7:2], write-enable [1], reserved [0] |
| addr_rdata | output | 8 | Latched address byte readback |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Data port write value |
| data_rdata | output | 8 | Register at the latched index |
| ctl_we | input | 1 | Clock control byte write strobe |
| ctl_wdata | input | 8 | Clock control byte: select [1:0], strobe [6] |
| ctl_rdata | output | 8 | Clock control byte readback, strobe bit zero |
| sel_strobe | output | 1 | One-cycle pulse after a strobed control write |
| active_sel | output | 2 | Active pixel clock select |
| active_fb_div | output | 8 | Feedback divider of the active clock |
| active_post_code | output | 2 | Post-divider code of the active clock |
| active_ext_post | output | 1 | Extended post-divider bit of the active clock |
| ref_div | output | 8 | Reference divider |
| mem_fb_div | output | 8 | Memory feedback divider |
| mem_post_code | output | 3 | Memory post-divider code |
| mem_ref_div3 | output | 1 | Memory code selects reference divide by 3 |
| mem_code_bad | output | 1 | Memory code is unsupported |

## Verification
The bench targets four corner cases:
- The same-cycle address-and-data write. A design that applied the new index at once would corrupt the register being newly addressed instead of the old one.
- Writes while the write-enable flag is clear, and writes to unimplemented indices. A design that ignored the flag, or decoded the index loosely, would alter a live divider or return nonzero data from an empty slot.
- All four select values, checked against distinct post codes and extended bits. This exposes a field taken at position s instead of 2s, or an off-by-one feedback base.
- Every extended code from 0 to 7. This shows whether codes 4 and 5 are classified correctly at the boundary.

// File: rtl/clkgen_regport_pkg.sv
package clkgen_regport_pkg;
    localparam int REG_W      = 8;
    localparam int IDX_W      = REG_W - 2;
    localparam int SEL_W      = 2;
    localparam int NUM_PIX    = 1 << SEL_W;
    localparam int STROBE_BIT = 6;
    localparam int MCODE_W    = 3;
    localparam int EXT_BASE   = 4;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             wr_en;
        logic [REG_W-1:0] ctl;
        logic             strobe;
    } front_t;

    typedef struct packed {
        logic [REG_W-1:0]              ref_div;
        logic [REG_W-1:0]              mfb;
        logic [REG_W-1:0]              post;
        logic [REG_W-1:0]              ext;
        logic [NUM_PIX-1:0][REG_W-1:0] fb;
    } bank_t;
endpackage

// File: rtl/clkgen_regport_front.sv
module clkgen_regport_front
    import clkgen_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_we,
    input  logic [REG_W-1:1] addr_hi,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_wr_en,
    output logic [REG_W-1:0] ctl_byte,
    output logic             strobe
);
    front_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_we) begin
            st_d.idx   = addr_hi[REG_W-1:2];
            st_d.wr_en = addr_hi[1];
        end
        if (ctl_we) begin
            st_d.ctl             = ctl_wdata;
            st_d.ctl[STROBE_BIT] = 1'b0;
        end
        st_d.strobe = ctl_we & ctl_wdata[STROBE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cur_idx   = st_q.idx;
    assign cur_wr_en = st_q.wr_en;
    assign ctl_byte  = st_q.ctl;
    assign strobe    = st_q.strobe;
endmodule

// File: rtl/clkgen_regport_bank.sv
module clkgen_regport_bank
    import clkgen_regport_pkg::*;
#(
    parameter int IDX_REF  = 2,
    parameter int IDX_MFB  = 4,
    parameter int IDX_POST = 5,
    parameter int IDX_FB0  = 7,
    parameter int IDX_EXT  = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             data_we,
    input  logic [REG_W-1:0] data_wdata,
    output logic [REG_W-1:0] rdata,
    output bank_t            regs
);
    bank_t bank_d, bank_q;

    logic               hit_ref, hit_mfb, hit_post, hit_ext;
    logic [NUM_PIX-1:0] hit_fb;
    logic               commit;

    assign hit_ref  = (idx == IDX_W'(IDX_REF));
    assign hit_mfb  = (idx == IDX_W'(IDX_MFB));
    assign hit_post = (idx == IDX_W'(IDX_POST));
    assign hit_ext  = (idx == IDX_W'(IDX_EXT));

    for (genvar g = 0; g < NUM_PIX; g++) begin : g_fb_hit
        assign hit_fb[g] = (idx == IDX_W'(IDX_FB0 + g));
    end

    assign commit = data_we & wr_en;

    always_comb begin
        bank_d = bank_q;
        if (commit) begin
            if (hit_ref)  bank_d.ref_div = data_wdata;
            if (hit_mfb)  bank_d.mfb     = data_wdata;
            if (hit_post) bank_d.post    = data_wdata;
            if (hit_ext)  bank_d.ext     = data_wdata;
            for (int i = 0; i < NUM_PIX; i++) begin
                if (hit_fb[i]) bank_d.fb[i] = data_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_ref)  rdata = bank_q.ref_div;
        if (hit_mfb)  rdata = bank_q.mfb;
        if (hit_post) rdata = bank_q.post;
        if (hit_ext)  rdata = bank_q.ext;
        for (int i = 0; i < NUM_PIX; i++) begin
            if (hit_fb[i]) rdata = bank_q.fb[i];
        end
    end

    assign regs = bank_q;
endmodule

// File: rtl/clkgen_regport_decode.sv
module clkgen_regport_decode
    import clkgen_regport_pkg::*;
(
    input  bank_t              regs,
    input  logic [SEL_W-1:0]   sel,
    output logic [REG_W-1:0]   active_fb_div,
    output logic [1:0]         active_post_code,
    output logic               active_ext_post,
    output logic [MCODE_W-1:0] mem_post_code,
    output logic               mem_ref_div3,
    output logic               mem_code_bad
);
    always_comb begin
        active_fb_div    = regs.fb[sel];
        active_post_code = regs.post[{sel, 1'b0} +: 2];
        active_ext_post  = regs.ext[EXT_BASE + int'(sel)];
        mem_post_code    = regs.ext[MCODE_W-1:0];
        mem_ref_div3     = (mem_post_code == MCODE_W'(4));
        mem_code_bad     = (mem_post_code > MCODE_W'(4));
    end
endmodule

// File: rtl/clkgen_regport.sv
module clkgen_regport
    import clkgen_regport_pkg::*;
#(
    parameter int IDX_REF  = 2,
    parameter int IDX_MFB  = 4,
    parameter int IDX_POST = 5,
    parameter int IDX_FB0  = 7,
    parameter int IDX_EXT  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_we,
    input  logic [REG_W-1:0]   addr_wdata,
    output logic [REG_W-1:0]   addr_rdata,
    input  logic               data_we,
    input  logic [REG_W-1:0]   data_wdata,
    output logic [REG_W-1:0]   data_rdata,
    input  logic               ctl_we,
    input  logic [REG_W-1:0]   ctl_wdata,
    output logic [REG_W-1:0]   ctl_rdata,
    output logic               sel_strobe,
    output logic [SEL_W-1:0]   active_sel,
    output logic [REG_W-1:0]   active_fb_div,
    output logic [1:0]         active_post_code,
    output logic               active_ext_post,
    output logic [REG_W-1:0]   ref_div,
    output logic [REG_W-1:0]   mem_fb_div,
    output logic [MCODE_W-1:0] mem_post_code,
    output logic               mem_ref_div3,
    output logic               mem_code_bad
);
    logic [IDX_W-1:0] cur_idx;
    logic             cur_wr_en;
    logic [REG_W-1:0] ctl_byte;
    bank_t            regs;

    clkgen_regport_front u_front (
        .clk       (clk),
        .rst       (rst),
        .addr_we   (addr_we),
        .addr_hi   (addr_wdata[REG_W-1:1]),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cur_idx   (cur_idx),
        .cur_wr_en (cur_wr_en),
        .ctl_byte  (ctl_byte),
        .strobe    (sel_strobe)
    );

    clkgen_regport_bank #(
        .IDX_REF  (IDX_REF),
        .IDX_MFB  (IDX_MFB),
        .IDX_POST (IDX_POST),
        .IDX_FB0  (IDX_FB0),
        .IDX_EXT  (IDX_EXT)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .idx        (cur_idx),
        .wr_en      (cur_wr_en),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .rdata      (data_rdata),
        .regs       (regs)
    );

    clkgen_regport_decode u_decode (
        .regs             (regs),
        .sel              (ctl_byte[SEL_W-1:0]),
        .active_fb_div    (active_fb_div),
        .active_post_code (active_post_code),
        .active_ext_post  (active_ext_post),
        .mem_post_code    (mem_post_code),
        .mem_ref_div3     (mem_ref_div3),
        .mem_code_bad     (mem_code_bad)
    );

    assign addr_rdata = {cur_idx, cur_wr_en, 1'b0};
    assign ctl_rdata  = ctl_byte;
    assign active_sel = ctl_byte[SEL_W-1:0];
    assign ref_div    = regs.ref_div;
    assign mem_fb_div = regs.mfb;
endmodule

// File: rtl/clkgen_regport_chk.sv
module clkgen_regport_chk #(
    parameter int IDX_REF  = 2,
    parameter int IDX_MFB  = 4,
    parameter int IDX_POST = 5,
    parameter int IDX_FB0  = 7,
    parameter int IDX_EXT  = 11
) (
    input logic       clk,
    input logic       rst,
    input logic       addr_we,
    input logic [7:0] addr_wdata,
    input logic [7:0] addr_rdata,
    input logic       data_we,
    input logic [7:0] data_wdata,
    input logic [7:0] data_rdata,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic       sel_strobe,
    input logic [1:0] active_sel
);
    logic [5:0] tgt;
    logic       tgt_impl;
    assign tgt = addr_rdata[7:2];
    assign tgt_impl = (tgt == 6'(IDX_REF)) || (tgt == 6'(IDX_MFB)) ||
                      (tgt == 6'(IDX_POST)) || (tgt == 6'(IDX_EXT)) ||
                      ((tgt >= 6'(IDX_FB0)) && (tgt <= 6'(IDX_FB0 + 3)));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_rdata == 8'h00 && ctl_rdata == 8'h00 && !sel_strobe));

    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (rst)
        addr_we |=> addr_rdata == {$past(addr_wdata[7:1]), 1'b0});

    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && addr_rdata[1] && tgt_impl) |=> data_rdata == $past(data_wdata));

    assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (data_we && !addr_we && !addr_rdata[1]) |=> $stable(data_rdata));

    assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !tgt_impl |-> data_rdata == 8'h00);

    assert_strobe_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[6]) |=> sel_strobe);

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        sel_strobe |-> $past(ctl_we && ctl_wdata[6]));

    assert_sel_update_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> active_sel == $past(ctl_wdata[1:0]));
endmodule

bind clkgen_regport clkgen_regport_chk #(
    .IDX_REF  (IDX_REF),
    .IDX_MFB  (IDX_MFB),
    .IDX_POST (IDX_POST),
    .IDX_FB0  (IDX_FB0),
    .IDX_EXT  (IDX_EXT)
) u_chk (.*);

// File: tb/clkgen_regport_tb.sv
module clkgen_regport_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_we = 1'b0, data_we = 1'b0, ctl_we = 1'b0;
    logic [7:0] addr_wdata = '0, data_wdata = '0, ctl_wdata = '0;
    logic [7:0] addr_rdata, data_rdata, ctl_rdata, active_fb_div, ref_div, mem_fb_div;
    logic       sel_strobe, active_ext_post, mem_ref_div3, mem_code_bad;
    logic [1:0] active_sel, active_post_code;
    logic [2:0] mem_post_code;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  chk_on   = 1'b0;
    bit  done     = 1'b0;

    // behavioural reference state
    logic [7:0] m_reg [0:63];
    int         m_idx = 0;
    bit         m_we  = 1'b0;
    logic [7:0] m_ctl = '0;
    bit         m_stb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_regport u_dut (
        .clk(clk), .rst(rst),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .addr_rdata(addr_rdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sel_strobe(sel_strobe), .active_sel(active_sel),
        .active_fb_div(active_fb_div), .active_post_code(active_post_code),
        .active_ext_post(active_ext_post), .ref_div(ref_div), .mem_fb_div(mem_fb_div),
        .mem_post_code(mem_post_code), .mem_ref_div3(mem_ref_div3), .mem_code_bad(mem_code_bad)
    );

    function automatic bit impl(input int i);
        return i == 2 || i == 4 || i == 5 || (i >= 7 && i <= 11);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
            m_idx = 0; m_we = 1'b0; m_ctl = 8'h00; m_stb = 1'b0;
        end else begin
            if (data_we && m_we && impl(m_idx)) m_reg[m_idx] = data_wdata;
            if (addr_we) begin
                m_idx = int'(addr_wdata[7:2]);
                m_we  = addr_wdata[1];
            end
            m_stb = ctl_we && ctl_wdata[6];
            if (ctl_we) m_ctl = ctl_wdata & 8'hBF;
        end
    end

    // compare every output with the reference each cycle
    always @(negedge clk) begin
        if (chk_on && !done) begin
            int s;
            logic [7:0] ex;
            s  = int'(m_ctl[1:0]);
            ex = m_reg[11];
            chk("R2 addr_rdata", addr_rdata, {m_idx[5:0], m_we, 1'b0});
            chk("R4 data_rdata", data_rdata, impl(m_idx) ? m_reg[m_idx] : 0);
            chk("R9 ctl_rdata", ctl_rdata, m_ctl);
            chk("R9 sel_strobe", sel_strobe, m_stb);
            chk("R9 active_sel", active_sel, s);
            chk("R6 active_fb_div", active_fb_div, m_reg[7 + s]);
            chk("R7 active_post_code", active_post_code, (m_reg[5] >> (2 * s)) & 3);
            chk("R8 active_ext_post", active_ext_post, ex[4 + s]);
            chk("R8 mem_post_code", mem_post_code, ex[2:0]);
            chk("R8 mem_ref_div3", mem_ref_div3, ex[2:0] == 3'd4);
            chk("R8 mem_code_bad", mem_code_bad, ex[2:0] >= 3'd5);
            chk("R10 ref_div", ref_div, m_reg[2]);
            chk("R10 mem_fb_div", mem_fb_div, m_reg[4]);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        addr_we = 1'b0; data_we = 1'b0; ctl_we = 1'b0;
    endtask

    task automatic set_addr(input int idx, input bit we);
        addr_we = 1'b1; addr_wdata = {idx[5:0], we, 1'b0}; tick();
    endtask

    task automatic reg_write(input int idx, input logic [7:0] v);
        set_addr(idx, 1'b1);
        data_we = 1'b1; data_wdata = v; tick();
        set_addr(idx, 1'b0);
    endtask

    task automatic reg_read_chk(input int idx, input int exp, input string tag);
        set_addr(idx, 1'b0);
        @(negedge clk);
        chk(tag, data_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 addr_rdata", addr_rdata, 0);
        chk("R1 ctl_rdata", ctl_rdata, 0);
        chk("R1 ref_div", ref_div, 0);
        chk("R1 sel_strobe", sel_strobe, 0);
        @(posedge clk); #1;

        // R10 / R6 / R7 / R8 programming
        reg_write(2, 8'h2A);
        reg_write(4, 8'h9C);
        reg_write(5, 8'hE4);
        for (int s = 0; s < 4; s++) reg_write(7 + s, 8'h80 + 8'(s * 17));
        reg_write(11, 8'h54);
        reg_read_chk(2, 8'h2A, "R10 ref readback");
        reg_read_chk(4, 8'h9C, "R10 mfb readback");
        reg_read_chk(9, 8'h80 + 34, "R6 fb2 readback");

        for (int s = 0; s < 4; s++) begin
            set_ctl(8'(s));
            @(negedge clk);
            chk("R6 fb per select", active_fb_div, 8'h80 + s * 17);
            chk("R7 post per select", active_post_code, s);
            chk("R8 ext bit per select", active_ext_post, (s % 2 == 0) ? 1 : 0);
            @(posedge clk); #1;
        end
        chk("R8 code4 div3", mem_ref_div3, 1);

        // R9: strobe pulse for one cycle, readback without strobe bit
        set_ctl(8'hC2);
        @(negedge clk);
        chk("R9 strobe high", sel_strobe, 1);
        chk("R9 ctl readback", ctl_rdata, 8'h82);
        @(negedge clk);
        chk("R9 strobe single cycle", sel_strobe, 0);
        @(posedge clk); #1;

        // R3: write with flag clear has no effect
        set_addr(2, 1'b0);
        data_we = 1'b1; data_wdata = 8'hFF; tick();
        @(negedge clk);
        chk("R3 write ignored", ref_div, 8'h2A);
        @(posedge clk); #1;

        // R4: unimplemented indices
        reg_write(20, 8'h77);
        reg_read_chk(20, 0, "R4 unimplemented 20");
        reg_write(0, 8'h55);
        reg_read_chk(0, 0, "R4 unimplemented 0");
        reg_read_chk(6, 0, "R4 unimplemented 6");

        // R2: reserved bit reads zero
        addr_we = 1'b1; addr_wdata = 8'h2F; tick();
        @(negedge clk);
        chk("R2 bit0 zero", addr_rdata, 8'h2E);
        @(posedge clk); #1;

        // R5: same-cycle address and data writes
        set_addr(2, 1'b1);
        addr_we = 1'b1; addr_wdata = {6'd4, 1'b1, 1'b0};
        data_we = 1'b1; data_wdata = 8'h11; tick();
        @(negedge clk);
        chk("R5 old index written", ref_div, 8'h11);
        chk("R5 new index untouched", mem_fb_div, 8'h9C);
        @(posedge clk); #1;

        // R8: all memory codes
        for (int c = 0; c < 8; c++) begin
            reg_write(11, 8'(c));
            @(negedge clk);
            chk("R8 div3 flag", mem_ref_div3, c == 4);
            chk("R8 bad flag", mem_code_bad, c >= 5);
            @(posedge clk); #1;
        end

        // random traffic against the reference
        for (int n = 0; n < 600; n++) begin
            addr_we    = ($urandom_range(0, 3) == 0);
            addr_wdata = {6'($urandom_range(0, 15)), 1'($urandom), 1'($urandom)};
            data_we    = ($urandom_range(0, 1) == 0);
            data_wdata = 8'($urandom);
            ctl_we     = ($urandom_range(0, 5) == 0);
            ctl_wdata  = 8'($urandom);
            @(posedge clk); #1;
        end
        addr_we = 1'b0; data_we = 1'b0; ctl_we = 1'b0;

        // R1: reset in mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid reset addr", addr_rdata, 0);
        chk("R1 mid reset ref", ref_div, 0);
        chk("R1 mid reset ext", mem_post_code, 0);
        @(posedge clk); #1;
        finish_run();
    end
endmodule